// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block produces the SCL waveform for an I2C bus master from a peripheral clock. Software supplies the peripheral clock frequency in MHz, the target bus speed in kHz and a duty selection. From these the block derives a single divider value and a rise-time limit count. The divider sets the phase lengths. In symmetric standard mode both phases last one divider each. In the 2:1 fast mode the low phase lasts two dividers and the high phase one. In the 16:9 fast mode they last sixteen and nine. A configuration is checked before it is stored. A mismatched or out-of-range request raises an error flag. A speed that the 12-bit divider cannot reach raises a separate flag. In both cases the old settings stay in force.

While enabled, the block alternates low and high phases. A strobe marks the start of each low phase and another marks the first cycle of each high phase in which SCL is seen high. The high-phase counter moves only while the sampled SCL line reads high. A device that holds the line low therefore stretches the bus clock without cutting the high time short. The bit engine that drives SDA uses the two strobes.

Top module: `scl_div_gen`

## Requirements
- R1: After reset, sclOut is 1 (released), divOut is 40, riseOut is 9, and cfgErr, tooSlow, fallStb and riseStb are all 0.
- R2: A write with cfgWe high while enable is low, with khzIn in 1..100 and dutyIn = 0 (symmetric), stores divOut = floor(mhzIn*1000 / (2*khzIn)), clamped to at least 4, and riseOut = mhzIn + 1.
- R3: A write with khzIn in 101..400 and dutyIn = 1 (2:1) stores divOut = floor(mhzIn*1000 / (3*khzIn)) and riseOut = floor(mhzIn*300/1000) + 1.
- R4: A write with khzIn in 101..400 and dutyIn = 2 (16:9) stores divOut = floor(mhzIn*1000 / (25*khzIn)), clamped to at least 1, with the same fast riseOut as R3.
- R5: A write is invalid if any of these holds: mhzIn outside 2..36; khzIn is 0 or above 400; dutyIn is 3; a fast duty with khzIn ≤ 100; symmetric duty with khzIn > 100. An invalid write sets cfgErr = 1 and leaves divOut and riseOut unchanged. The next stored write clears cfgErr.
- R6: A valid write whose quotient exceeds 4095 sets tooSlow = 1 and cfgErr = 0, and leaves divOut and riseOut unchanged. The next stored write clears tooSlow.
- R7: A write while enable is high has no effect on divOut, riseOut or cfgErr.
- R8: The low phase lasts 1, 2 or 16 times divOut cycles for duty 0, 1 or 2. fallStb is high only in its first cycle.
- R9: When sclIn follows sclOut, the high phase lasts 1, 1 or 9 times divOut cycles for duty 0, 1 or 2.
- R10: Each cycle in which sclIn is low while sclOut is released adds one cycle to the high phase. riseStb pulses once per high phase, in the first cycle in which sclIn is high.
- R11: Dropping enable releases sclOut in the next cycle. Raising it again starts a full-length low phase with fallStb in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the SCL generator; configuration is locked while high |
| cfgWe | input | 1 | Configuration write strobe |
| mhzIn | input | 6 | Peripheral clock frequency in MHz |
| khzIn | input | 9 | Target bus speed in kHz |
| dutyIn | input | 2 | 0 symmetric, 1 low:high 2:1, 2 low:high 16:9 |
| sclIn | input | 1 | Sampled SCL line level, already synchronised |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| fallStb | output | 1 | First cycle of a low phase |
| riseStb | output | 1 | First cycle of a high phase with SCL seen high |
| divOut | output | 12 | Stored divider value |
| riseOut | output | 6 | Stored rise-time limit count |
| cfgErr | output | 1 | Last accepted write was invalid |
| tooSlow | output | 1 | Last accepted write asked for an unreachable speed |

## Verification
Configuration results register on the clock edge that samples cfgWe. The bench drives each write at a falling edge and reads divOut, riseOut and both flags at the very next falling edge. sclOut and fallStb change together on the edge after the one that acts, so a phase is measured by counting falling-edge samples from the one where fallStb is first high. riseStb depends on sclIn within the same cycle, so the bench changes its stretch input at a falling edge and waits a short delay before sampling riseStb in that cycle.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] DUTY_SYM   = 2'd0;
  localparam logic [1:0] DUTY_2TO1  = 2'd1;
  localparam logic [1:0] DUTY_16TO9 = 2'd2;

  typedef struct packed {
    logic clear;
    logic advance;
  } cnt_ctrl_t;

endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_div_pkg::*;
#(
  parameter int MHZ_W        = 6,
  parameter int KHZ_W        = 9,
  parameter int DIV_W        = 12,
  parameter int RISE_W       = 6,
  parameter int MHZ_MIN      = 2,
  parameter int MHZ_MAX      = 36,
  parameter int STD_MAX_KHZ  = 100,
  parameter int FAST_MAX_KHZ = 400,
  parameter int STD_FLOOR    = 4,
  parameter int FAST_FLOOR   = 1,
  parameter int RST_DIV      = 40,
  parameter int RST_RISE     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cfgWe,
  input  logic [MHZ_W-1:0]  mhzIn,
  input  logic [KHZ_W-1:0]  khzIn,
  input  logic [1:0]        dutyIn,
  output logic [DIV_W-1:0]  divOut,
  output logic [RISE_W-1:0] riseOut,
  output logic [1:0]        dutyOut,
  output logic              cfgErr,
  output logic              tooSlow
);

  localparam int NUM_W = MHZ_W + KHZ_W + 10;
  localparam logic [MHZ_W-1:0] MHZ_LO   = MHZ_W'(MHZ_MIN);
  localparam logic [MHZ_W-1:0] MHZ_HI   = MHZ_W'(MHZ_MAX);
  localparam logic [KHZ_W-1:0] STD_LIM  = KHZ_W'(STD_MAX_KHZ);
  localparam logic [KHZ_W-1:0] FAST_LIM = KHZ_W'(FAST_MAX_KHZ);
  localparam logic [NUM_W-1:0] DIV_MAX  = NUM_W'((1 << DIV_W) - 1);

  logic             isFast;
  logic             badCfg;
  logic             tooBig;
  logic [NUM_W-1:0] num, den, denSafe, quot, floorVal, divCalc, riseCalc;
  logic [NUM_W-1:0] weight;

  always_comb begin
    isFast = khzIn > STD_LIM;
    num    = NUM_W'(mhzIn) * NUM_W'(1000);
    if (!isFast)                   weight = NUM_W'(2);
    else if (dutyIn == DUTY_16TO9) weight = NUM_W'(25);
    else                           weight = NUM_W'(3);
    den      = NUM_W'(khzIn) * weight;
    denSafe  = (den == '0) ? NUM_W'(1) : den;
    quot     = num / denSafe;
    floorVal = isFast ? NUM_W'(FAST_FLOOR) : NUM_W'(STD_FLOOR);
    divCalc  = (quot < floorVal) ? floorVal : quot;
    tooBig   = divCalc > DIV_MAX;
    riseCalc = isFast ? (NUM_W'(mhzIn) * NUM_W'(300)) / NUM_W'(1000) + NUM_W'(1)
                      : NUM_W'(mhzIn) + NUM_W'(1);
    badCfg   = (mhzIn < MHZ_LO) || (mhzIn > MHZ_HI) ||
               (khzIn == '0) || (khzIn > FAST_LIM) ||
               (dutyIn == 2'd3) ||
               (isFast && (dutyIn == DUTY_SYM)) ||
               (!isFast && (dutyIn != DUTY_SYM));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divOut  <= DIV_W'(RST_DIV);
      riseOut <= RISE_W'(RST_RISE);
      dutyOut <= DUTY_SYM;
      cfgErr  <= 1'b0;
      tooSlow <= 1'b0;
    end else if (cfgWe && !enable) begin
      cfgErr  <= badCfg;
      tooSlow <= !badCfg && tooBig;
      if (!badCfg && !tooBig) begin
        divOut  <= DIV_W'(divCalc);
        riseOut <= RISE_W'(riseCalc);
        dutyOut <= dutyIn;
      end
    end
  end

  // R7: settings frozen while running
  p_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ($stable(divOut) && $stable(riseOut) && $stable(cfgErr)));
  // R6: an unreachable speed never replaces the divider
  p_slow_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tooSlow) |-> $stable(divOut));
  // R4: the stored divider is never zero
  p_div_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    divOut != '0);

endmodule

// File: rtl/scl_div_cnt.sv
module scl_div_cnt
  import scl_div_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_ctrl_t        ctl,
  input  logic [DIV_W-1:0] divIn,
  input  logic [1:0]       dutyIn,
  output logic             lowDone,
  output logic             highDone
);

  localparam int UNIT_W = 4;

  logic [DIV_W-1:0]  tick, tickLast;
  logic [UNIT_W-1:0] unit, lowLast, highLast;

  always_comb begin
    case (dutyIn)
      DUTY_2TO1:  begin lowLast = UNIT_W'(1);  highLast = UNIT_W'(0); end
      DUTY_16TO9: begin lowLast = UNIT_W'(15); highLast = UNIT_W'(8); end
      default:    begin lowLast = UNIT_W'(0);  highLast = UNIT_W'(0); end
    endcase
    tickLast = divIn - DIV_W'(1);
    lowDone  = (tick == tickLast) && (unit == lowLast);
    highDone = (tick == tickLast) && (unit == highLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      tick <= '0;
      unit <= '0;
    end else if (ctl.advance) begin
      if (tick == tickLast) begin
        tick <= '0;
        unit <= unit + UNIT_W'(1);
      end else begin
        tick <= tick + DIV_W'(1);
      end
    end
  end

  // R8: tick counter stays inside one divider period
  p_tick_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick <= tickLast);

endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sclIn,
  input  logic      lowDone,
  input  logic      highDone,
  output cnt_ctrl_t ctl,
  output logic      sclOut,
  output logic      fallStb,
  output logic      riseStb
);

  phase_e state, nextState;
  logic   seenHigh;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        ctl.clear = 1'b1;
        if (enable) nextState = ST_LOW;
      end
      ST_LOW: begin
        ctl.advance = 1'b1;
        if (lowDone) begin
          nextState = ST_HIGH;
          ctl.clear = 1'b1;
        end
      end
      ST_HIGH: begin
        ctl.advance = sclIn;
        if (sclIn && highDone) begin
          nextState = ST_LOW;
          ctl.clear = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (!enable) begin
      nextState = ST_IDLE;
      ctl.clear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fallStb  <= 1'b0;
      seenHigh <= 1'b0;
    end else begin
      state    <= nextState;
      fallStb  <= (nextState == ST_LOW) && (state != ST_LOW);
      seenHigh <= (state == ST_HIGH) && (nextState == ST_HIGH) && (seenHigh || sclIn);
    end
  end

  assign sclOut  = (state != ST_LOW);
  assign riseStb = (state == ST_HIGH) && sclIn && !seenHigh;

  // R8: one fall strobe per low phase
  p_fall_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |=> !fallStb);
  // R10: a held-low line keeps the high phase open
  p_stretch_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && !sclIn && enable) |=> (state == ST_HIGH));
  // R10: rise strobe lasts one cycle
  p_rise_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb);
  // R11: disabling releases the line
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> sclOut);

endmodule

// File: rtl/scl_div_gen.sv
module scl_div_gen
  import scl_div_pkg::*;
#(
  parameter int MHZ_W  = 6,
  parameter int KHZ_W  = 9,
  parameter int DIV_W  = 12,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cfgWe,
  input  logic [MHZ_W-1:0]  mhzIn,
  input  logic [KHZ_W-1:0]  khzIn,
  input  logic [1:0]        dutyIn,
  input  logic              sclIn,
  output logic              sclOut,
  output logic              fallStb,
  output logic              riseStb,
  output logic [DIV_W-1:0]  divOut,
  output logic [RISE_W-1:0] riseOut,
  output logic              cfgErr,
  output logic              tooSlow
);

  cnt_ctrl_t  ctl;
  logic [1:0] dutyCur;
  logic       lowDone, highDone;

  scl_div_cfg #(
    .MHZ_W(MHZ_W), .KHZ_W(KHZ_W), .DIV_W(DIV_W), .RISE_W(RISE_W)
  ) cfg_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe),
    .mhzIn(mhzIn), .khzIn(khzIn), .dutyIn(dutyIn),
    .divOut(divOut), .riseOut(riseOut), .dutyOut(dutyCur),
    .cfgErr(cfgErr), .tooSlow(tooSlow)
  );

  scl_div_cnt #(.DIV_W(DIV_W)) cnt_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divIn(divOut), .dutyIn(dutyCur),
    .lowDone(lowDone), .highDone(highDone)
  );

  scl_div_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
    .lowDone(lowDone), .highDone(highDone), .ctl(ctl),
    .sclOut(sclOut), .fallStb(fallStb), .riseStb(riseStb)
  );

endmodule

// File: tb/scl_div_gen_tb.sv
module scl_div_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN, enable, cfgWe, stretch;
  logic [5:0]  mhzIn;
  logic [8:0]  khzIn;
  logic [1:0]  dutyIn;
  logic        sclIn, sclOut, fallStb, riseStb, cfgErr, tooSlow;
  logic [11:0] divOut;
  logic [5:0]  riseOut;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign sclIn = sclOut & ~stretch;

  scl_div_gen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe),
    .mhzIn(mhzIn), .khzIn(khzIn), .dutyIn(dutyIn), .sclIn(sclIn),
    .sclOut(sclOut), .fallStb(fallStb), .riseStb(riseStb),
    .divOut(divOut), .riseOut(riseOut), .cfgErr(cfgErr), .tooSlow(tooSlow)
  );

  typedef struct packed {
    logic [5:0]  mhz;
    logic [8:0]  khz;
    logic [1:0]  duty;
    logic        err;
    logic        slow;
    logic [11:0] div;
    logic [5:0]  rise;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{6'd8,  9'd100, 2'd0, 1'b0, 1'b0, 12'd40,  6'd9 },  // R2
    '{6'd36, 9'd100, 2'd0, 1'b0, 1'b0, 12'd180, 6'd37},  // R2
    '{6'd2,  9'd100, 2'd0, 1'b0, 1'b0, 12'd10,  6'd3 },  // R2
    '{6'd36, 9'd400, 2'd1, 1'b0, 1'b0, 12'd30,  6'd11},  // R3
    '{6'd36, 9'd400, 2'd2, 1'b0, 1'b0, 12'd3,   6'd11},  // R4
    '{6'd2,  9'd400, 2'd2, 1'b0, 1'b0, 12'd1,   6'd1 },  // R4 clamp
    '{6'd8,  9'd400, 2'd0, 1'b1, 1'b0, 12'd1,   6'd1 },  // R5 fast speed, symmetric duty
    '{6'd8,  9'd100, 2'd1, 1'b1, 1'b0, 12'd1,   6'd1 },  // R5 standard speed, fast duty
    '{6'd36, 9'd1,   2'd0, 1'b0, 1'b1, 12'd1,   6'd1 },  // R6
    '{6'd9,  9'd10,  2'd0, 1'b0, 1'b0, 12'd450, 6'd10},  // R2, clears R6 flag
    '{6'd1,  9'd100, 2'd0, 1'b1, 1'b0, 12'd450, 6'd10},  // R5 clock too low
    '{6'd16, 9'd250, 2'd1, 1'b0, 1'b0, 12'd21,  6'd5 },  // R3, clears R5 flag
    '{6'd10, 9'd101, 2'd1, 1'b0, 1'b0, 12'd33,  6'd4 },  // R3 boundary
    '{6'd10, 9'd100, 2'd1, 1'b1, 1'b0, 12'd33,  6'd4 },  // R5 boundary
    '{6'd10, 9'd0,   2'd0, 1'b1, 1'b0, 12'd33,  6'd4 },  // R5 zero speed
    '{6'd10, 9'd401, 2'd1, 1'b1, 1'b0, 12'd33,  6'd4 },  // R5 speed too high
    '{6'd37, 9'd100, 2'd0, 1'b1, 1'b0, 12'd33,  6'd4 },  // R5 clock too high
    '{6'd10, 9'd100, 2'd3, 1'b1, 1'b0, 12'd33,  6'd4 }   // R5 reserved duty
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [5:0] m, input logic [8:0] k, input logic [1:0] d);
    mhzIn = m; khzIn = k; dutyIn = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic measure(input int expLow, input int expHigh, input int stretchN,
                         input string tag);
    int guard = 0;
    int lowCnt = 0;
    int highCnt = 0;
    int riseAt = -1;
    do begin
      @(negedge clk);
      guard++;
    end while (!fallStb && guard < 2000);
    chk(fallStb == 1'b1, {tag, " fall strobe"}, fallStb, 1);
    while (sclOut == 1'b0 && lowCnt < 2000) begin
      lowCnt++;
      @(negedge clk);
    end
    while (sclOut == 1'b1 && highCnt < 2000) begin
      stretch = (highCnt < stretchN);
      #1;
      if (riseStb && riseAt < 0) riseAt = highCnt;
      highCnt++;
      @(negedge clk);
    end
    stretch = 1'b0;
    chk(lowCnt == expLow, {tag, " low length"}, lowCnt, expLow);
    chk(highCnt == expHigh, {tag, " high length"}, highCnt, expHigh);
    chk(riseAt == stretchN, {tag, " rise strobe position"}, riseAt, stretchN);
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; cfgWe = 1'b0; stretch = 1'b0;
    mhzIn = '0; khzIn = '0; dutyIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclOut == 1'b1, "R1 sclOut", sclOut, 1);
    chk(divOut == 12'd40, "R1 divOut", divOut, 40);
    chk(riseOut == 6'd9, "R1 riseOut", riseOut, 9);
    chk(cfgErr == 1'b0 && tooSlow == 1'b0, "R1 flags", {cfgErr, tooSlow}, 0);
    chk(fallStb == 1'b0 && riseStb == 1'b0, "R1 strobes", {fallStb, riseStb}, 0);

    for (int i = 0; i < NVEC; i++) begin
      write_cfg(VEC[i].mhz, VEC[i].khz, VEC[i].duty);
      chk(cfgErr == VEC[i].err, $sformatf("table row %0d cfgErr", i), cfgErr, VEC[i].err);
      chk(tooSlow == VEC[i].slow, $sformatf("table row %0d tooSlow", i), tooSlow, VEC[i].slow);
      chk(divOut == VEC[i].div, $sformatf("table row %0d divOut", i), divOut, VEC[i].div);
      chk(riseOut == VEC[i].rise, $sformatf("table row %0d riseOut", i), riseOut, VEC[i].rise);
    end

    // R7: write while enabled is ignored (settings 33/4, cfgErr 1 from last row)
    enable = 1'b1;
    write_cfg(6'd8, 9'd100, 2'd0);
    chk(divOut == 12'd33, "R7 divOut unchanged", divOut, 33);
    chk(riseOut == 6'd4, "R7 riseOut unchanged", riseOut, 4);
    chk(cfgErr == 1'b1, "R7 cfgErr unchanged", cfgErr, 1);
    enable = 1'b0;
    @(negedge clk);

    // R8 R9: 2:1, divider 6 -> low 12, high 6
    write_cfg(6'd8, 9'd400, 2'd1);
    chk(divOut == 12'd6, "R3 divOut 2:1 setup", divOut, 6);
    enable = 1'b1;
    measure(12, 6, 0, "R8 R9 2:1");
    enable = 1'b0;
    @(negedge clk);

    // R8 R9: 16:9, divider 1 -> low 16, high 9
    write_cfg(6'd2, 9'd400, 2'd2);
    enable = 1'b1;
    measure(16, 9, 0, "R8 R9 16:9");
    enable = 1'b0;
    @(negedge clk);

    // R8 R9: symmetric, divider 10 -> low 10, high 10
    write_cfg(6'd2, 9'd100, 2'd0);
    enable = 1'b1;
    measure(10, 10, 0, "R8 R9 symmetric");
    // R10: 5 cycles held low add to high phase
    measure(10, 15, 5, "R10 stretch");
    enable = 1'b0;
    @(negedge clk);

    // R11: drop enable mid low phase, then restart
    write_cfg(6'd8, 9'd400, 2'd1);
    enable = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sclOut == 1'b0, "R11 running low", sclOut, 0);
    enable = 1'b0;
    @(negedge clk);
    chk(sclOut == 1'b1, "R11 released", sclOut, 1);
    chk(fallStb == 1'b0, "R11 no strobe when idle", fallStb, 0);
    enable = 1'b1;
    measure(12, 6, 0, "R11 restart");
    enable = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule